// File: doc/BRIEF.md
# Four-Mode 16-bit Barrel Shifter

This block moves a 16-bit operand by 0 to 15 bit positions in one of four ways: circular rotation toward the MSB, a left shift that brings in zeros, a right shift that copies the sign bit into the vacated top bits, and a right shift that brings in zeros. It is purely combinational. The result follows the operand, amount and mode inputs with no clock edge in between, so the block can sit inside a datapath such as an ALU result mux.

The shift is built as a logarithmic network of cascaded stages. Stage k moves the data by 2^k positions when bit k of the amount is set, and passes it through when that bit is clear. A small decoder turns the 2-bit mode into three controls that every stage shares: the direction, whether bits wrap around, and the value shifted in.

Top module: `bshift16`

## Requirements
- R1: With `mode` = 2'b00, `data_out` is `data_in` rotated toward the MSB by `shamt` positions. Bits that leave bit 15 re-enter at bit 0.
- R2: With `mode` = 2'b01, `data_out` is `data_in` shifted toward the MSB by `shamt` positions, and the `shamt` low bits are zero.
- R3: With `mode` = 2'b10, `data_out` is `data_in` shifted toward the LSB by `shamt` positions, and the `shamt` high bits are copies of `data_in[15]`.
- R4: With `mode` = 2'b11, `data_out` is `data_in` shifted toward the LSB by `shamt` positions, and the `shamt` high bits are zero.
- R5: When `shamt` = 0, `data_out` equals `data_in` in every mode.
- R6: The block holds no state. A change on any input shows up at `data_out` without any clock edge.
- R7: The full amount of 15 works in every mode. For example, a left shift of 0x0001 by 15 gives 0x8000, and an arithmetic right shift of 0x8000 by 15 gives 0xFFFF.
- R8: A rotation keeps the number of set bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 16 | Operand to be moved |
| shamt | input | 4 | Number of positions, 0 to 15 |
| mode | input | 2 | 00 rotate left, 01 shift left, 10 arithmetic right, 11 logical right |
| data_out | output | 16 | Shifted or rotated result |

## Verification
The bench drives the operands 0x8000, 0x0001, 0xFFFF and 0x0000 through every mode and every amount. These are the values that reveal a wrong fill value: a sign fill taken from the wrong bit, zeros shifted into a rotation, or a sign copy leaking into the logical right shift. Amount 0 and amount 15 are exercised in each mode. A stage wired to the wrong distance, or a swapped enable bit, would fail at these ends and at the amounts in between. Seeded random operands then cover the mixed bit patterns, where a stage that drops a single wrapped bit would show a wrong result.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    MODE_ROL = 2'b00,
    MODE_SHL = 2'b01,
    MODE_ASR = 2'b10,
    MODE_LSR = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/bshift_ctl.sv
module bshift_ctl
  import bshift_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       msb,
  output logic       to_right,
  output logic       wrap,
  output logic       fill
);
  shift_mode_e m;
  assign m = shift_mode_e'(mode);

  always_comb begin
    to_right = 1'b0;
    wrap     = 1'b0;
    fill     = 1'b0;
    unique case (m)
      MODE_ROL: wrap = 1'b1;
      MODE_SHL: ;
      MODE_ASR: begin
        to_right = 1'b1;
        fill     = msb;
      end
      MODE_LSR: to_right = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int WIDTH = 16,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             en,
  input  logic             to_right,
  input  logic             wrap,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  logic [DIST-1:0]  fill_vec;
  logic [WIDTH-1:0] left_v;
  logic [WIDTH-1:0] right_v;

  assign fill_vec = {DIST{fill}};
  assign left_v   = {din[WIDTH-1-DIST:0], (wrap ? din[WIDTH-1 -: DIST] : fill_vec)};
  assign right_v  = {fill_vec, din[WIDTH-1:DIST]};

  always_comb begin
    if (!en)           dout = din;
    else if (to_right) dout = right_v;
    else               dout = left_v;
  end
endmodule

// File: rtl/bshift16.sv
module bshift16 #(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] shamt,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] data_out
);
  localparam int NSTAGE = AMT_W;

  logic             to_right;
  logic             wrap;
  logic             fill;
  logic [WIDTH-1:0] lvl [NSTAGE+1];

  bshift_ctl u_ctl (
    .mode     (mode),
    .msb      (data_in[WIDTH-1]),
    .to_right (to_right),
    .wrap     (wrap),
    .fill     (fill)
  );

  assign lvl[0] = data_in;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    bshift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
      .din      (lvl[k]),
      .en       (shamt[k]),
      .to_right (to_right),
      .wrap     (wrap),
      .fill     (fill),
      .dout     (lvl[k+1])
    );
  end

  assign data_out = lvl[NSTAGE];

  // Port-level checks
  logic [WIDTH-1:0] lo_mask;
  logic [WIDTH-1:0] hi_mask;
  assign lo_mask = ~({WIDTH{1'b1}} << shamt);
  assign hi_mask = ~({WIDTH{1'b1}} >> shamt);

  always_comb begin
    if (!$isunknown({data_in, shamt, mode, data_out})) begin
      if (shamt == '0)
        p_zero_pass_r5: assert (data_out == data_in);
      if (mode == 2'b00)
        p_rot_popcount_r8: assert ($countones(data_out) == $countones(data_in));
      if (mode == 2'b01)
        p_shl_low_zero_r2: assert ((data_out & lo_mask) == '0);
      if (mode == 2'b10)
        p_asr_sign_fill_r3: assert ((data_out & hi_mask) == (data_in[WIDTH-1] ? hi_mask : '0));
      if (mode == 2'b11)
        p_lsr_high_zero_r4: assert ((data_out & hi_mask) == '0);
    end
  end
endmodule

// File: tb/bshift16_tb.sv
module bshift16_tb;
  logic        clk = 1'b0;
  logic [15:0] data_in;
  logic [3:0]  shamt;
  logic [1:0]  mode;
  logic [15:0] data_out;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bshift16 u_dut (
    .data_in  (data_in),
    .shamt    (shamt),
    .mode     (mode),
    .data_out (data_out)
  );

  function automatic logic [15:0] model(input logic [15:0] d, input logic [3:0] a, input logic [1:0] m);
    logic [31:0] dd;
    case (m)
      2'b00: begin dd = {d, d} << a; return dd[31:16]; end
      2'b01: return d << a;
      2'b10: return 16'($signed(d) >>> a);
      default: return d >> a;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a, input logic [1:0] m);
    if (a == 4'd0) return "R5";
    if (a == 4'd15) return "R7";
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_cmp++;
    if (data_out !== exp) begin
      n_bad++;
      $display("FAIL %s: in=%h amt=%0d mode=%b actual=%h expected=%h",
               req, data_in, shamt, mode, data_out, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic [3:0] a, input logic [1:0] m);
    @(posedge clk);
    #1;
    data_in = d; shamt = a; mode = m;
    @(negedge clk);
    check(req_of(a, m), model(d, a, m));
  endtask

  initial begin
    logic [15:0] corner [4];
    corner[0] = 16'h8000; corner[1] = 16'h0001;
    corner[2] = 16'hFFFF; corner[3] = 16'h0000;
    data_in = '0; shamt = '0; mode = '0;
    void'($urandom(32'd1234));
    // R5 first: amount zero passes the operand
    apply(16'hA5C3, 4'd0, 2'b00);
    // R7 directed extremes
    apply(16'h0001, 4'd15, 2'b01); check("R7", 16'h8000);
    apply(16'h8000, 4'd15, 2'b10); check("R7", 16'hFFFF);
    apply(16'h8000, 4'd15, 2'b11); check("R7", 16'h0001);
    apply(16'h8000, 4'd15, 2'b00); check("R7", 16'h4000);
    // R1..R5 corners across all modes and amounts
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 16; a++)
          apply(corner[c], 4'(a), 2'(m));
    // R8 rotation of a mixed value
    apply(16'h1234, 4'd4, 2'b00); check("R8", 16'h2341);
    // R6: change inputs with no clock edge in between
    @(negedge clk);
    data_in = 16'h00F0; shamt = 4'd4; mode = 2'b11;
    #0.5; check("R6", 16'h000F);
    mode = 2'b01;
    #0.5; check("R6", 16'h0F00);
    data_in = 16'hF000; mode = 2'b10;
    #0.5; check("R6", 16'hFF00);
    // random
    for (int i = 0; i < 2000; i++)
      apply(16'($urandom), 4'($urandom), 2'($urandom));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule